// File: doc/BRIEF.md
# Microprogrammed Control Sequencer

This block drives the control points of a multi-cycle processor datapath from a small microcode store. A micro-address register selects one microword. Each microword carries the datapath control bits and a two-bit sequencing field. A separate next-address stage uses that field to pick the following micro-address from four candidates:

- a jump back to the fetch word,
- an entry in one of two opcode-indexed dispatch tables,
- the current micro-address plus one.

The opcode input comes from the datapath's instruction register. It is consulted only in the decode word and in the address-compute word. Every other step is fixed by the microcode alone. The outputs are decoded from the registered micro-address only, so they are stable for a whole cycle. There is no streaming data path: all pins are plain level signals that are sampled on the rising clock edge.

Top module: `useq_ctrl`

## Requirements
- R1: While `rst_n` is low, `uaddr` is 0 and the outputs show the fetch word. Reset is asynchronous: it takes effect at once, even in the middle of an instruction.
- R2: The fetch word (uaddr 0) drives the following:
  - `pc_load`=1, `mem_read_en`=1, `instr_load`=1, `addr_from_alu`=0;
  - `alu_opnd_a_sel`=0 (0 selects PC, 1 selects register A);
  - `alu_opnd_b_sel`=01 (00 selects B, 01 selects constant 4, 10 selects the sign-extended immediate, 11 selects the immediate shifted left by two);
  - `alu_func_sel`=00 (00 add, 01 subtract, 10 funct field);
  - `pc_next_sel`=00 (00 ALU result, 01 ALU output register, 10 jump target).

  The next micro-address is always 1, whatever the opcode.
- R3: The decode word (uaddr 1) drives a_sel=0, b_sel=11 and func=00, with all other bits 0. The next micro-address comes from dispatch table 1:
  - opcode 6'h00 (register-register) goes to 6;
  - 6'h02 (jump) goes to 8;
  - 6'h04 (branch-if-equal) goes to 9;
  - 6'h23 (load) and 6'h2B (store) both go to 2.
- R4: Any other opcode at decode returns the sequencer to uaddr 0.
- R5: The address word (uaddr 2) drives a_sel=1, b_sel=10 and func=00. The next micro-address comes from dispatch table 2: 6'h23 goes to 3, 6'h2B goes to 5, and any other opcode goes to 0.
- R6: A load runs through uaddr 0,1,2,3,4 and then returns to 0.
  - uaddr 3 drives `mem_read_en`=1 and `addr_from_alu`=1.
  - uaddr 4 drives `rf_write_en`=1, `rf_data_from_mem`=1 and `rf_dst_from_rd`=0.
- R7: A store runs through uaddr 0,1,2,5 and then returns to 0. uaddr 5 drives `mem_write_en`=1 and `addr_from_alu`=1.
- R8: A register-register op runs through uaddr 0,1,6,7 and then returns to 0.
  - uaddr 6 drives a_sel=1, b_sel=00 and func=10.
  - uaddr 7 drives `rf_write_en`=1 and `rf_dst_from_rd`=1.
- R9: A branch runs through uaddr 0,1,9 and then returns to 0. uaddr 9 drives a_sel=1, b_sel=00, func=01, `pc_load_if_zero`=1 and `pc_next_sel`=01.
- R10: A jump runs through uaddr 0,1,8 and then returns to 0. uaddr 8 drives `pc_load`=1 and `pc_next_sel`=10.
- R11: The opcode has no effect in uaddr 0, 3, 4, 5, 6, 7, 8 and 9.
- R12: `mem_read_en` and `mem_write_en` are never high together. `rf_write_en` is high only in uaddr 4 and 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| opcode | input | 6 | Opcode field from the instruction register |
| uaddr | output | 4 | Current micro-address |
| pc_load | output | 1 | Unconditional program counter write |
| pc_load_if_zero | output | 1 | Program counter write when the ALU zero flag is set |
| addr_from_alu | output | 1 | Memory address taken from the ALU output register (0: PC) |
| mem_read_en | output | 1 | Memory read |
| mem_write_en | output | 1 | Memory write |
| instr_load | output | 1 | Instruction register load |
| rf_data_from_mem | output | 1 | Register write data from the memory data register (0: ALU output) |
| pc_next_sel | output | 2 | Program counter source |
| alu_func_sel | output | 2 | ALU function class |
| alu_opnd_b_sel | output | 2 | ALU second operand select |
| alu_opnd_a_sel | output | 1 | ALU first operand select |
| rf_write_en | output | 1 | Register file write |
| rf_dst_from_rd | output | 1 | Destination register from the rd field (0: rt) |

## Verification
A wrong micro-address shows up on `uaddr` and on the control word in the same cycle that it is registered. A wrong dispatch entry therefore shows one edge after decode or after the address word. A corrupted microword shows the same cycle it is addressed, as a control bit that does not match that step. A sequencing field that skips or repeats a step makes an instruction last the wrong number of cycles, which the bench sees at the next expected return to fetch. Opcode changes in the steps where the opcode must not matter are checked by walking the full sequence.

// File: rtl/useq_pkg.sv
package useq_pkg;
  localparam int OP_W = 6;
  localparam int UA_W = 4;
  localparam int N_STATES = 10;

  typedef enum logic [1:0] {
    SEQ_FETCH = 2'd0,
    SEQ_DISP1 = 2'd1,
    SEQ_DISP2 = 2'd2,
    SEQ_NEXT  = 2'd3
  } seq_ctl_e;

  typedef struct packed {
    logic       pc_load;
    logic       pc_load_if_zero;
    logic       addr_from_alu;
    logic       mem_read_en;
    logic       mem_write_en;
    logic       instr_load;
    logic       rf_data_from_mem;
    logic [1:0] pc_next_sel;
    logic [1:0] alu_func_sel;
    logic [1:0] alu_opnd_b_sel;
    logic       alu_opnd_a_sel;
    logic       rf_write_en;
    logic       rf_dst_from_rd;
  } ctrl_word_t;

  localparam logic [OP_W-1:0] OPC_REG   = 6'h00;
  localparam logic [OP_W-1:0] OPC_JUMP  = 6'h02;
  localparam logic [OP_W-1:0] OPC_BEQ   = 6'h04;
  localparam logic [OP_W-1:0] OPC_LOAD  = 6'h23;
  localparam logic [OP_W-1:0] OPC_STORE = 6'h2B;

  localparam int ST_FETCH  = 0;
  localparam int ST_DECODE = 1;
  localparam int ST_ADDR   = 2;
  localparam int ST_MRD    = 3;
  localparam int ST_LDWB   = 4;
  localparam int ST_STWR   = 5;
  localparam int ST_EXEC   = 6;
  localparam int ST_REGWB  = 7;
  localparam int ST_JUMP   = 8;
  localparam int ST_BRANCH = 9;
endpackage

// File: rtl/useq_ucode_rom.sv
module useq_ucode_rom
  import useq_pkg::*;
#(
  parameter int UA_W_P = UA_W
) (
  input  logic [UA_W_P-1:0] addr,
  output ctrl_word_t        word,
  output seq_ctl_e          seq
);
  always_comb begin
    word = '0;
    seq  = SEQ_FETCH;
    case (int'(addr))
      ST_FETCH: begin
        word.mem_read_en    = 1'b1;
        word.instr_load     = 1'b1;
        word.alu_opnd_b_sel = 2'b01;
        word.pc_load        = 1'b1;
        seq = SEQ_NEXT;
      end
      ST_DECODE: begin
        word.alu_opnd_b_sel = 2'b11;
        seq = SEQ_DISP1;
      end
      ST_ADDR: begin
        word.alu_opnd_a_sel = 1'b1;
        word.alu_opnd_b_sel = 2'b10;
        seq = SEQ_DISP2;
      end
      ST_MRD: begin
        word.mem_read_en   = 1'b1;
        word.addr_from_alu = 1'b1;
        seq = SEQ_NEXT;
      end
      ST_LDWB: begin
        word.rf_write_en      = 1'b1;
        word.rf_data_from_mem = 1'b1;
      end
      ST_STWR: begin
        word.mem_write_en  = 1'b1;
        word.addr_from_alu = 1'b1;
      end
      ST_EXEC: begin
        word.alu_opnd_a_sel = 1'b1;
        word.alu_func_sel   = 2'b10;
        seq = SEQ_NEXT;
      end
      ST_REGWB: begin
        word.rf_write_en    = 1'b1;
        word.rf_dst_from_rd = 1'b1;
      end
      ST_JUMP: begin
        word.pc_load     = 1'b1;
        word.pc_next_sel = 2'b10;
      end
      ST_BRANCH: begin
        word.alu_opnd_a_sel  = 1'b1;
        word.alu_func_sel    = 2'b01;
        word.pc_load_if_zero = 1'b1;
        word.pc_next_sel     = 2'b01;
      end
      default: begin
        word = '0;
        seq  = SEQ_FETCH;
      end
    endcase
  end
endmodule

// File: rtl/useq_dispatch_rom.sv
module useq_dispatch_rom
  import useq_pkg::*;
#(
  parameter int TABLE_ID = 1,
  parameter int OP_W_P   = OP_W,
  parameter int UA_W_P   = UA_W
) (
  input  logic [OP_W_P-1:0] op,
  output logic [UA_W_P-1:0] target
);
  generate
    if (TABLE_ID == 1) begin : g_table_decode
      always_comb begin
        case (op)
          OPC_REG:   target = UA_W_P'(ST_EXEC);
          OPC_JUMP:  target = UA_W_P'(ST_JUMP);
          OPC_BEQ:   target = UA_W_P'(ST_BRANCH);
          OPC_LOAD,
          OPC_STORE: target = UA_W_P'(ST_ADDR);
          default:   target = UA_W_P'(ST_FETCH);
        endcase
      end
    end else begin : g_table_memop
      always_comb begin
        case (op)
          OPC_LOAD:  target = UA_W_P'(ST_MRD);
          OPC_STORE: target = UA_W_P'(ST_STWR);
          default:   target = UA_W_P'(ST_FETCH);
        endcase
      end
    end
  endgenerate
endmodule

// File: rtl/useq_next_addr.sv
module useq_next_addr
  import useq_pkg::*;
#(
  parameter int UA_W_P = UA_W
) (
  input  seq_ctl_e          seq,
  input  logic [UA_W_P-1:0] cur,
  input  logic [UA_W_P-1:0] disp1,
  input  logic [UA_W_P-1:0] disp2,
  output logic [UA_W_P-1:0] nxt
);
  logic [UA_W_P-1:0] inc;
  assign inc = cur + UA_W_P'(1);

  always_comb begin
    case (seq)
      SEQ_FETCH: nxt = '0;
      SEQ_DISP1: nxt = disp1;
      SEQ_DISP2: nxt = disp2;
      default:   nxt = inc;
    endcase
  end
endmodule

// File: rtl/useq_ctrl.sv
module useq_ctrl
  import useq_pkg::*;
#(
  parameter int OPW = OP_W,
  parameter int UAW = UA_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [OPW-1:0] opcode,
  output logic [UAW-1:0] uaddr,
  output logic           pc_load,
  output logic           pc_load_if_zero,
  output logic           addr_from_alu,
  output logic           mem_read_en,
  output logic           mem_write_en,
  output logic           instr_load,
  output logic           rf_data_from_mem,
  output logic [1:0]     pc_next_sel,
  output logic [1:0]     alu_func_sel,
  output logic [1:0]     alu_opnd_b_sel,
  output logic           alu_opnd_a_sel,
  output logic           rf_write_en,
  output logic           rf_dst_from_rd
);
  logic [UAW-1:0] upc_q, upc_d, d1_tgt, d2_tgt;
  ctrl_word_t     word;
  seq_ctl_e       seq;

  useq_ucode_rom #(.UA_W_P(UAW)) u_rom (
    .addr(upc_q), .word(word), .seq(seq)
  );

  useq_dispatch_rom #(.TABLE_ID(1), .OP_W_P(OPW), .UA_W_P(UAW)) u_disp1 (
    .op(opcode), .target(d1_tgt)
  );

  useq_dispatch_rom #(.TABLE_ID(2), .OP_W_P(OPW), .UA_W_P(UAW)) u_disp2 (
    .op(opcode), .target(d2_tgt)
  );

  useq_next_addr #(.UA_W_P(UAW)) u_nxt (
    .seq(seq), .cur(upc_q), .disp1(d1_tgt), .disp2(d2_tgt), .nxt(upc_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) upc_q <= '0;
    else        upc_q <= upc_d;
  end

  assign uaddr            = upc_q;
  assign pc_load          = word.pc_load;
  assign pc_load_if_zero  = word.pc_load_if_zero;
  assign addr_from_alu    = word.addr_from_alu;
  assign mem_read_en      = word.mem_read_en;
  assign mem_write_en     = word.mem_write_en;
  assign instr_load       = word.instr_load;
  assign rf_data_from_mem = word.rf_data_from_mem;
  assign pc_next_sel      = word.pc_next_sel;
  assign alu_func_sel     = word.alu_func_sel;
  assign alu_opnd_b_sel   = word.alu_opnd_b_sel;
  assign alu_opnd_a_sel   = word.alu_opnd_a_sel;
  assign rf_write_en      = word.rf_write_en;
  assign rf_dst_from_rd   = word.rf_dst_from_rd;
endmodule

// File: rtl/useq_ctrl_chk.sv
module useq_ctrl_chk #(
  parameter int OPW = 6,
  parameter int UAW = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic [OPW-1:0] opcode,
  input logic [UAW-1:0] uaddr,
  input logic           mem_read_en,
  input logic           mem_write_en,
  input logic           rf_write_en
);
  logic op_known;
  assign op_known = (opcode == 6'h00) || (opcode == 6'h02) || (opcode == 6'h04) ||
                    (opcode == 6'h23) || (opcode == 6'h2B);

  p_fetch_to_decode_r2: assert property (@(posedge clk) disable iff (!rst_n)
    uaddr == UAW'(0) |=> uaddr == UAW'(1));

  p_decode_reg_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (uaddr == UAW'(1) && opcode == 6'h00) |=> uaddr == UAW'(6));

  p_decode_branch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (uaddr == UAW'(1) && opcode == 6'h04) |=> uaddr == UAW'(9));

  p_decode_unknown_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (uaddr == UAW'(1) && !op_known) |=> uaddr == UAW'(0));

  p_addr_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (uaddr == UAW'(2) && opcode == 6'h23) |=> uaddr == UAW'(3));

  p_addr_store_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (uaddr == UAW'(2) && opcode == 6'h2B) |=> uaddr == UAW'(5));

  p_load_steps_r6: assert property (@(posedge clk) disable iff (!rst_n)
    uaddr == UAW'(3) |=> uaddr == UAW'(4));

  p_reg_steps_r8: assert property (@(posedge clk) disable iff (!rst_n)
    uaddr == UAW'(6) |=> uaddr == UAW'(7));

  p_terminal_return_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (uaddr == UAW'(4) || uaddr == UAW'(5) || uaddr == UAW'(7) ||
     uaddr == UAW'(8) || uaddr == UAW'(9)) |=> uaddr == UAW'(0));

  p_mem_exclusive_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_read_en && mem_write_en));

  p_rf_write_steps_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rf_write_en |-> (uaddr == UAW'(4) || uaddr == UAW'(7)));

  p_uaddr_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    uaddr < UAW'(10));
endmodule

bind useq_ctrl useq_ctrl_chk #(.OPW(OPW), .UAW(UAW)) u_chk (
  .clk(clk), .rst_n(rst_n), .opcode(opcode), .uaddr(uaddr),
  .mem_read_en(mem_read_en), .mem_write_en(mem_write_en),
  .rf_write_en(rf_write_en)
);

// File: tb/test_useq_ctrl.sv
module test_useq_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] opcode = 6'h00;
  logic [3:0] uaddr;
  logic       pc_load, pc_load_if_zero, addr_from_alu, mem_read_en, mem_write_en;
  logic       instr_load, rf_data_from_mem, alu_opnd_a_sel, rf_write_en, rf_dst_from_rd;
  logic [1:0] pc_next_sel, alu_func_sel, alu_opnd_b_sel;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  useq_ctrl i_useq_ctrl (
    .clk(clk), .rst_n(rst_n), .opcode(opcode), .uaddr(uaddr),
    .pc_load(pc_load), .pc_load_if_zero(pc_load_if_zero),
    .addr_from_alu(addr_from_alu), .mem_read_en(mem_read_en),
    .mem_write_en(mem_write_en), .instr_load(instr_load),
    .rf_data_from_mem(rf_data_from_mem), .pc_next_sel(pc_next_sel),
    .alu_func_sel(alu_func_sel), .alu_opnd_b_sel(alu_opnd_b_sel),
    .alu_opnd_a_sel(alu_opnd_a_sel), .rf_write_en(rf_write_en),
    .rf_dst_from_rd(rf_dst_from_rd)
  );

  function automatic logic [15:0] exp_word(input int s);
    logic pl = 0, pz = 0, ad = 0, mr = 0, mw = 0, il = 0, dm = 0, a = 0, we = 0, rd = 0;
    logic [1:0] ps = 0, fn = 0, bs = 0;
    case (s)
      0: begin pl = 1; mr = 1; il = 1; bs = 2'b01; end
      1: bs = 2'b11;
      2: begin a = 1; bs = 2'b10; end
      3: begin mr = 1; ad = 1; end
      4: begin we = 1; dm = 1; end
      5: begin mw = 1; ad = 1; end
      6: begin a = 1; fn = 2'b10; end
      7: begin we = 1; rd = 1; end
      8: begin pl = 1; ps = 2'b10; end
      9: begin a = 1; fn = 2'b01; pz = 1; ps = 2'b01; end
      default: ;
    endcase
    return {pl, pz, ad, mr, mw, il, dm, ps, fn, bs, a, we, rd};
  endfunction

  function automatic logic [15:0] act_word();
    return {pc_load, pc_load_if_zero, addr_from_alu, mem_read_en, mem_write_en,
            instr_load, rf_data_from_mem, pc_next_sel, alu_func_sel, alu_opnd_b_sel,
            alu_opnd_a_sel, rf_write_en, rf_dst_from_rd};
  endfunction

  task automatic check_now(input int s, input string tag);
    n_chk++;
    if (uaddr !== 4'(s) || act_word() !== exp_word(s)) begin
      n_fail++;
      $display("FAIL %s: uaddr=%0d word=%h expected uaddr=%0d word=%h",
               tag, uaddr, act_word(), s, exp_word(s));
    end
  endtask

  task automatic step(input int s, input string tag);
    check_now(s, tag);
    @(negedge clk);
  endtask

  task automatic t_reset_r1();
    repeat (3) @(negedge clk);
    check_now(0, "R1 held reset");
    rst_n = 1'b1;
  endtask

  task automatic t_load_r6();
    opcode = 6'h23;
    step(0, "R2 fetch"); step(1, "R3 decode"); step(2, "R5 addr");
    step(3, "R6 mem read"); step(4, "R6 load writeback");
  endtask

  task automatic t_store_r7();
    opcode = 6'h2B;
    step(0, "R7 fetch"); step(1, "R7 decode"); step(2, "R5 addr"); step(5, "R7 store");
  endtask

  task automatic t_reg_r8();
    opcode = 6'h00;
    step(0, "R8 fetch"); step(1, "R3 decode"); step(6, "R8 exec"); step(7, "R8 writeback");
  endtask

  task automatic t_branch_r9();
    opcode = 6'h04;
    step(0, "R9 fetch"); step(1, "R3 decode"); step(9, "R9 branch");
  endtask

  task automatic t_jump_r10();
    opcode = 6'h02;
    step(0, "R10 fetch"); step(1, "R3 decode"); step(8, "R10 jump");
  endtask

  task automatic t_unknown_r4();
    opcode = 6'h3F;
    step(0, "R4 fetch"); step(1, "R4 decode unknown");
    opcode = 6'h11;
    step(0, "R4 back to fetch"); step(1, "R4 decode unknown 2");
  endtask

  task automatic t_disp2_other_r5();
    opcode = 6'h23;
    step(0, "R5 fetch"); step(1, "R5 decode");
    opcode = 6'h04;
    step(2, "R5 addr with non-memory opcode");
  endtask

  task automatic t_ignored_r11();
    opcode = 6'h3F;
    step(0, "R11 fetch ignores opcode");
    opcode = 6'h23;
    step(1, "R11 decode"); step(2, "R11 addr");
    opcode = 6'h04;
    step(3, "R11 mem read ignores opcode");
    opcode = 6'h00;
    step(4, "R11 writeback ignores opcode");
    opcode = 6'h00;
    step(0, "R11 fetch");
    step(1, "R11 decode");
    opcode = 6'h2B;
    step(6, "R11 exec ignores opcode");
    step(7, "R11 reg writeback ignores opcode");
  endtask

  task automatic t_mid_reset_r1();
    opcode = 6'h23;
    step(0, "R1 fetch"); step(1, "R1 decode"); step(2, "R1 addr");
    rst_n = 1'b0;
    #1;
    check_now(0, "R1 async reset mid-instruction");
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    t_reset_r1();
    t_load_r6();
    t_store_r7();
    t_reg_r8();
    t_branch_r9();
    t_jump_r10();
    t_unknown_r4();
    t_disp2_other_r5();
    t_ignored_r11();
    t_mid_reset_r1();
    t_load_r6();
    step(0, "R6 back to fetch");
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule